// File: doc/BRIEF.md
# Min-Sum Check Node Unit for a Weight-Six LDPC Row

This block is the check-side processing element of a min-sum LDPC decoder for a regular code whose parity rows each connect to six bit nodes. It takes all six bit-to-check messages of one row in a single parallel word. It returns six check-to-bit messages. Each outgoing message leaves out its own edge: its magnitude is the smallest magnitude among the other five inputs, and its sign is the product of the other five signs.

Messages are 5-bit two's complement words with one sign bit, two integer bits and two fraction bits. Internally the unit splits every input into a sign and a 4-bit magnitude. It finds the smallest and second-smallest magnitudes and records which edge holds the smallest. From these it forms each edge's result and converts it back to two's complement.

The input side uses a valid/ready handshake. The result sits in one output register, so a row is answered one cycle after it is accepted. A new row can be taken every cycle while the consumer keeps taking results.

Top module: `cnu_min_sum`

## Requirements
- R1: While reset is asserted, and right after it, out_valid is 0, out_msgs is all zeros and in_ready is 1.
- R2: The magnitude of output lane i is the minimum of the magnitudes of the five input lanes other than i. Lane i occupies bits [5i+4:5i].
- R3: The sign of output lane i is the XOR of the sign bits (bit 4 of each lane) of the five other input lanes. A negative sign with zero magnitude is emitted as code 00000.
- R4: Inputs and outputs are 5-bit two's complement values, read as 1 sign, 2 integer and 2 fraction bits, so 00100 means +1.0 and 11100 means -1.0.
- R5: Input code 10000 (-4.0) is taken as magnitude 15 (3.75) with a negative sign. No output lane ever carries code 10000.
- R6: When several inputs share the smallest magnitude, every output lane receives that magnitude, including the lanes that hold it.
- R7: A row accepted on a clock edge (in_valid and in_ready both 1) appears on out_msgs with out_valid 1 after that edge.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_msgs and out_valid hold their values.
- R9: With out_ready held at 1, a new row is accepted on every edge. out_valid falls after an edge on which the output is taken and no new row is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A row of six messages is offered |
| in_ready | output | 1 | The unit can take a row this cycle |
| in_msgs | input | 30 | Six bit-to-check messages, lane i at bits [5i+4:5i] |
| out_valid | output | 1 | out_msgs holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_msgs | output | 30 | Six check-to-bit messages, same lane layout |

## Verification
The bench builds the unit with its default widths: six lanes of five bits each. At this size all 32 input codes, including the lone -4.0 code, can occur in every lane. Tie-heavy random rows drawn from a handful of values exercise shared minima, zeros with negative parity and saturation, and are checked against a brute-force exclusion reference. Directed handshake sequences cover back-to-back rows, stalls under back-pressure and draining.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int CNU_MSG_W = 5;
  localparam int CNU_DEG   = 6;
endpackage

// File: rtl/cnu_to_sm.sv
module cnu_to_sm #(
  parameter int MSG_W = cnu_pkg::CNU_MSG_W,
  localparam int MW = MSG_W - 1
) (
  input  logic [MSG_W-1:0] code,
  output logic             sign,
  output logic [MW-1:0]    mag
);
  function automatic logic [MW-1:0] sat_abs(input logic [MSG_W-1:0] c);
    logic [MSG_W-1:0] neg;
    neg = ~c + 1'b1;
    if (c == {1'b1, {MW{1'b0}}}) return {MW{1'b1}};
    else if (c[MSG_W-1])          return neg[MW-1:0];
    else                          return c[MW-1:0];
  endfunction

  assign sign = code[MSG_W-1];
  assign mag  = sat_abs(code);
endmodule

// File: rtl/cnu_min_pair.sv
module cnu_min_pair #(
  parameter int DEG = cnu_pkg::CNU_DEG,
  parameter int MW  = cnu_pkg::CNU_MSG_W - 1,
  localparam int IW = $clog2(DEG)
) (
  input  logic [DEG-1:0][MW-1:0] mags,
  output logic [MW-1:0]          min1,
  output logic [MW-1:0]          min2,
  output logic [IW-1:0]          min_idx
);
  always_comb begin
    min1    = {MW{1'b1}};
    min2    = {MW{1'b1}};
    min_idx = '0;
    for (int k = 0; k < DEG; k++) begin
      if (mags[k] < min1) begin
        min2    = min1;
        min1    = mags[k];
        min_idx = IW'(k);
      end else if (mags[k] < min2) begin
        min2 = mags[k];
      end
    end
  end
endmodule

// File: rtl/cnu_edge_out.sv
module cnu_edge_out #(
  parameter int MSG_W = cnu_pkg::CNU_MSG_W,
  parameter int DEG   = cnu_pkg::CNU_DEG,
  parameter int LANE  = 0,
  localparam int MW = MSG_W - 1,
  localparam int IW = $clog2(DEG)
) (
  input  logic             sign_all,
  input  logic             own_sign,
  input  logic [MW-1:0]    min1,
  input  logic [MW-1:0]    min2,
  input  logic [IW-1:0]    min_idx,
  output logic [MSG_W-1:0] code
);
  function automatic logic [MSG_W-1:0] sm_to_tc(input logic s, input logic [MW-1:0] m);
    logic [MSG_W-1:0] ext;
    ext = {1'b0, m};
    return s ? (~ext + 1'b1) : ext;
  endfunction

  logic          lane_sign;
  logic [MW-1:0] lane_mag;

  assign lane_sign = sign_all ^ own_sign;
  assign lane_mag  = (min_idx == IW'(LANE)) ? min2 : min1;
  assign code      = sm_to_tc(lane_sign, lane_mag);
endmodule

// File: rtl/cnu_min_sum.sv
module cnu_min_sum #(
  parameter int MSG_W = cnu_pkg::CNU_MSG_W,
  parameter int DEG   = cnu_pkg::CNU_DEG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DEG*MSG_W-1:0] in_msgs,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DEG*MSG_W-1:0] out_msgs
);
  localparam int MW = MSG_W - 1;
  localparam int IW = $clog2(DEG);

  logic [DEG-1:0][MSG_W-1:0] in_lanes;
  logic [DEG-1:0]            signs;
  logic [DEG-1:0][MW-1:0]    mags;
  logic                      sign_all;
  logic [MW-1:0]             min1;
  logic [MW-1:0]             min2;
  logic [IW-1:0]             min_idx;
  logic [DEG-1:0][MSG_W-1:0] next_lanes;
  logic [DEG-1:0][MSG_W-1:0] out_q;
  logic                      accept;

  assign in_lanes = in_msgs;
  assign sign_all = ^signs;

  for (genvar g = 0; g < DEG; g++) begin : g_split
    cnu_to_sm #(.MSG_W(MSG_W)) u_sm (
      .code (in_lanes[g]),
      .sign (signs[g]),
      .mag  (mags[g])
    );
  end

  cnu_min_pair #(.DEG(DEG), .MW(MW)) u_min (
    .mags    (mags),
    .min1    (min1),
    .min2    (min2),
    .min_idx (min_idx)
  );

  for (genvar g = 0; g < DEG; g++) begin : g_edge
    cnu_edge_out #(.MSG_W(MSG_W), .DEG(DEG), .LANE(g)) u_out (
      .sign_all (sign_all),
      .own_sign (signs[g]),
      .min1     (min1),
      .min2     (min2),
      .min_idx  (min_idx),
      .code     (next_lanes[g])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) out_q <= next_lanes;
    end
  end

  assign out_msgs = out_q;
endmodule

// File: rtl/cnu_min_sum_chk.sv
module cnu_min_sum_chk #(
  parameter int MSG_W = cnu_pkg::CNU_MSG_W,
  parameter int DEG   = cnu_pkg::CNU_DEG,
  localparam int MW = MSG_W - 1,
  localparam int IW = $clog2(DEG)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DEG*MSG_W-1:0] out_msgs,
  input logic [DEG-1:0][MW-1:0] mags,
  input logic [MW-1:0]        min1,
  input logic [MW-1:0]        min2,
  input logic [IW-1:0]        min_idx
);
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n) min1 <= min2);
  p_holder_r6: assert property (@(posedge clk) disable iff (!rst_n) mags[min_idx] == min1);

  for (genvar g = 0; g < DEG; g++) begin : g_lane
    p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n) mags[g] >= min1);
    p_no_low_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_msgs[g*MSG_W +: MSG_W] != {1'b1, {MW{1'b0}}});
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_msgs));
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

bind cnu_min_sum cnu_min_sum_chk #(.MSG_W(MSG_W), .DEG(DEG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_msgs  (out_msgs),
  .mags      (mags),
  .min1      (min1),
  .min2      (min2),
  .min_idx   (min_idx)
);

// File: tb/cnu_min_sum_test.sv
module cnu_min_sum_test;
  localparam int W  = 5;
  localparam int D  = 6;
  localparam int BW = W * D;
  localparam int NT = 8;

  // each entry: {input row, expected row}, lane 5 leftmost
  localparam logic [2*BW-1:0] TBL [NT] = '{
    {{6{5'b00000}}, {6{5'b00000}}},
    {{6{5'b00100}}, {6{5'b00100}}},
    {{{5{5'b00010}}, 5'b10000}, {{5{5'b11110}}, 5'b00010}},
    {{{4{5'b00111}}, 5'b11101, 5'b00011}, {{4{5'b11101}}, 5'b00011, 5'b11101}},
    {{6{5'b01111}}, {6{5'b01111}}},
    {{5'b10001, 5'b01010, 5'b11110, 5'b00101, 5'b11000, 5'b00001},
     {5'b00001, 5'b11111, 5'b00001, 5'b11111, 5'b00001, 5'b11110}},
    {{{5{5'b11111}}, 5'b00000}, {{5{5'b00000}}, 5'b11111}},
    {{5'b00011, {4{5'b11111}}, 5'b00000}, {{5{5'b00000}}, 5'b00001}}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_msgs = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [BW-1:0] out_msgs;
  int            checks = 0;
  int            errors = 0;

  always #5 clk = ~clk;

  cnu_min_sum uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_msgs(in_msgs), .out_valid(out_valid), .out_ready(out_ready), .out_msgs(out_msgs)
  );

  function automatic logic [BW-1:0] reference(input logic [BW-1:0] row);
    logic [BW-1:0] res;
    for (int i = 0; i < D; i++) begin
      int best;
      int neg;
      int val;
      best = 15;
      neg = 0;
      for (int j = 0; j < D; j++) begin
        if (j != i) begin
          int a;
          val = int'($signed(row[j*W +: W]));
          a = (val < 0) ? -val : val;
          if (a > 15) a = 15;
          if (a < best) best = a;
          if (val < 0) neg = 1 - neg;
        end
      end
      val = (neg == 1) ? -best : best;
      res[i*W +: W] = W'(val);
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [BW-1:0] row, input string req);
    @(negedge clk);
    in_msgs = row;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid", BW'(out_valid), BW'(1));
    check(req, out_msgs, reference(row));
  endtask

  function automatic logic [BW-1:0] tie_row();
    logic [BW-1:0] r;
    for (int k = 0; k < D; k++) begin
      case ($urandom % 6)
        0: r[k*W +: W] = 5'b00000;
        1: r[k*W +: W] = 5'b00001;
        2: r[k*W +: W] = 5'b11111;
        3: r[k*W +: W] = 5'b10000;
        4: r[k*W +: W] = 5'b01111;
        default: r[k*W +: W] = 5'b00010;
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] ra;
    logic [BW-1:0] rb;
    repeat (3) @(negedge clk);
    check("R1 out_valid", BW'(out_valid), BW'(0));
    check("R1 out_msgs", out_msgs, '0);
    check("R1 in_ready", BW'(in_ready), BW'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {out_msgs[BW-2:0], out_valid}, '0);

    // R2 R3 R4 R5 R6: table walk, against stored and reference results
    for (int t = 0; t < NT; t++) begin
      send(TBL[t][2*BW-1:BW], "R2 R3 R4 table/reference");
      check("R2 R3 R5 R6 table", out_msgs, TBL[t][BW-1:0]);
    end

    for (int n = 0; n < 300; n++) send(BW'({$urandom, $urandom}), "R2 R3 random");
    for (int n = 0; n < 300; n++) send(tie_row(), "R5 R6 tie-heavy");

    // R9: back-to-back rows, then drain
    ra = tie_row();
    rb = BW'({$urandom, $urandom});
    @(negedge clk);
    in_msgs = ra; in_valid = 1'b1;
    @(negedge clk);
    check("R9 in_ready", BW'(in_ready), BW'(1));
    check("R9 first", out_msgs, reference(ra));
    in_msgs = rb;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second", out_msgs, reference(rb));
    @(negedge clk);
    check("R9 drained", BW'(out_valid), BW'(0));

    // R8: stall holds the result and blocks input
    out_ready = 1'b0;
    @(negedge clk);
    in_msgs = ra; in_valid = 1'b1;
    @(negedge clk);
    check("R8 held row", out_msgs, reference(ra));
    check("R8 in_ready low", BW'(in_ready), BW'(0));
    in_msgs = rb;
    @(negedge clk);
    check("R8 still held", out_msgs, reference(ra));
    check("R8 still valid", BW'(out_valid), BW'(1));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 release", out_msgs, reference(rb));
    @(negedge clk);
    check("R9 empty", BW'(out_valid), BW'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule